// File: doc/BRIEF.md
# Multiplexed Segment Display Scan Sequencer

This block produces the time-multiplexed drive pattern for a segment display with up to nine common lines and forty-three segment lines. A dot memory holds one bit per dot, one row per common. The sequencer activates one common per time slot, and a frame is one pass over the commons that are in use. In every slot the addressed common is driven to the select level. Each segment takes the select or non-select level according to its stored bit in the row of that common.

The outputs are symbolic two-bit level codes per pin, together with a frame phase bit. A separate analog stage turns these into voltages and inverts them on alternate frames, so that the average drive is zero. Configuration inputs set the following:

- the number of commons scanned (duty 1 to 9);
- reversal of the physical common order;
- a global blank that forces every segment off while leaving the dot memory untouched;
- the bias scheme, which decides which code idle commons carry;
- the slot length in clock ticks.

Top module: `lcdm_seq`

## Requirements
- R1: While reset is held, physical common 0 carries SEL (code 1), every other common carries the idle code of the current bias setting, every segment carries UNSEL (code 2) and frame_phase is 0.
- R2: After reset release, the slots visit logical commons 0, 1, ..., D-1 in turn and then start again, where D is the effective duty. Each slot lasts slot_len clock cycles, a slot_len of 0 acting as 1, and the first slot begins at the first clock edge after release.
- R3: Common pin k uses bits [2k+1:2k] of com_lvl. The common of the current slot is SEL (1). A common whose logical index is at or above D is OFF (0). All other commons are MID (3) when cfg_bias3 is 0 and UNSEL (2) when it is 1.
- R4: With cfg_mirror set, physical common pin p carries logical common NCOM-1-p.
- R5: Segment j uses bits [2j+1:2j] of seg_lvl. In the slot of logical common s it is SEL (1) when bit j of dot row s is 1 and UNSEL (2) otherwise, and it changes only at slot starts.
- R6: frame_phase toggles each time the scan returns from the last slot to slot 0. At duty 1 it therefore toggles every slot.
- R7: A write with wr_en stores wr_data (bit j = segment j) into row wr_row. The new row is shown from the next slot start that loads that row. A write at the very edge that loads the same row leaves the old data shown for that slot.
- R8: cfg_blank, sampled at each slot start, drives every segment to UNSEL for that slot whatever the dot data. The dot memory is kept, so clearing the blank shows the stored data again from the next slot start.
- R9: A change of effective duty or of cfg_mirror restarts the scan at slot 0 on the next clock edge, with a fresh full-length slot and frame_phase unchanged.
- R10: A cfg_duty of 0 or above NCOM acts as duty NCOM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_duty | input | IW (4) | Number of commons scanned |
| cfg_mirror | input | 1 | Reverse physical common order |
| cfg_bias3 | input | 1 | 1: idle commons UNSEL; 0: idle commons MID |
| cfg_blank | input | 1 | Force all segments to UNSEL |
| slot_len | input | LENW (8) | Clock cycles per slot |
| wr_en | input | 1 | Dot memory write strobe |
| wr_row | input | IW (4) | Row (logical common) to write |
| wr_data | input | NSEG (43) | Dot bits of the row |
| com_lvl | output | 2*NCOM (18) | Level code per common pin |
| seg_lvl | output | 2*NSEG (86) | Level code per segment pin |
| frame_phase | output | 1 | Drive polarity of the current frame |

## Verification
Two functions can meet on the same clock edge. A dot-memory write can land at the very edge where the slot boundary loads that same row. Separately, a configuration change can take over the scan partway through a frame. The bench issues a row write timed to arrive exactly at the load of that row. It then expects the old row for the slot that just began and the new row one frame later. It also flips the mirror option and then the duty in the middle of a slot. It expects slot 0 with the new mapping on the next edge, frame_phase left as it was, and full-length slots from that point onward.

// File: rtl/lcdm_pkg.sv
package lcdm_pkg;
  typedef enum logic [1:0] {
    LV_OFF   = 2'd0,
    LV_SEL   = 2'd1,
    LV_UNSEL = 2'd2,
    LV_MID   = 2'd3
  } lvl_e;
endpackage

// File: rtl/lcdm_timebase.sv
module lcdm_timebase #(
  parameter int LENW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LENW-1:0] slot_len,
  input  logic            restart,
  output logic            boundary
);
  logic [LENW-1:0] tick_q, tick_d, last_tick;
  logic            tick_en;

  always_comb begin
    last_tick = (slot_len == '0) ? '0 : slot_len - LENW'(1);
    boundary  = (tick_q >= last_tick);
    tick_en   = 1'b1;
    tick_d    = (boundary || restart) ? '0 : tick_q + LENW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tick_q <= '0;
    else if (tick_en) tick_q <= tick_d;
  end
endmodule

// File: rtl/lcdm_scan.sv
module lcdm_scan #(
  parameter int NCOM = 9,
  parameter int IW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] cfg_duty,
  input  logic          cfg_mirror,
  input  logic          cfg_blank,
  input  logic          boundary,
  output logic          load,
  output logic [IW-1:0] slot_nxt,
  output logic [IW-1:0] slot_q,
  output logic [IW-1:0] duty_q,
  output logic          mirror_q,
  output logic          blank_q,
  output logic          phase_q
);
  logic [IW-1:0] duty_eff;
  logic          start_q, cfg_chg, restart, wrap, phase_d;

  always_comb begin
    duty_eff = ((cfg_duty == '0) || (cfg_duty > IW'(NCOM))) ? IW'(NCOM) : cfg_duty;
    cfg_chg  = (duty_eff != duty_q) || (cfg_mirror != mirror_q);
    restart  = start_q || cfg_chg;
    load     = restart || boundary;
    wrap     = ((slot_q + IW'(1)) >= duty_q);
    if (restart)   slot_nxt = '0;
    else if (wrap) slot_nxt = '0;
    else           slot_nxt = slot_q + IW'(1);
    phase_d  = (!restart && boundary && wrap) ? ~phase_q : phase_q;
  end

  // configuration register, refreshed every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q   <= IW'(NCOM);
      mirror_q <= 1'b0;
      start_q  <= 1'b1;
    end else begin
      duty_q   <= duty_eff;
      mirror_q <= cfg_mirror;
      start_q  <= 1'b0;
    end
  end

  // slot state, advanced on load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      blank_q <= 1'b1;
      phase_q <= 1'b0;
    end else if (load) begin
      slot_q  <= slot_nxt;
      blank_q <= cfg_blank;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/lcdm_dotmem.sv
module lcdm_dotmem #(
  parameter int NCOM = 9,
  parameter int NSEG = 43,
  parameter int IW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_row,
  input  logic [NSEG-1:0] wr_data,
  input  logic            load,
  input  logic [IW-1:0]   rd_row,
  output logic [NSEG-1:0] row_q
);
  logic [NSEG-1:0] mem_q [NCOM];
  logic [NSEG-1:0] rd_data;

  for (genvar r = 0; r < NCOM; r++) begin : g_row
    logic row_we;
    assign row_we = wr_en && (wr_row == IW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[r] <= '0;
      else if (row_we) mem_q[r] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NCOM; r++) begin
      if (rd_row == IW'(r)) rd_data = mem_q[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row_q <= '0;
    else if (load) row_q <= rd_data;
  end
endmodule

// File: rtl/lcdm_drive.sv
module lcdm_drive
  import lcdm_pkg::*;
#(
  parameter int NCOM = 9,
  parameter int NSEG = 43,
  parameter int IW   = 4
) (
  input  logic [IW-1:0]     slot_q,
  input  logic [IW-1:0]     duty_q,
  input  logic              mirror_q,
  input  logic              bias3,
  input  logic              blank_q,
  input  logic [NSEG-1:0]   row_q,
  output logic [2*NCOM-1:0] com_lvl,
  output logic [2*NSEG-1:0] seg_lvl
);
  for (genvar p = 0; p < NCOM; p++) begin : g_com
    localparam logic [IW-1:0] LG_DIR = IW'(p);
    localparam logic [IW-1:0] LG_MIR = IW'(NCOM - 1 - p);
    logic [IW-1:0] lg;
    lvl_e          code;
    always_comb begin
      lg = mirror_q ? LG_MIR : LG_DIR;
      if (lg == slot_q)      code = LV_SEL;
      else if (lg >= duty_q) code = LV_OFF;
      else if (bias3)        code = LV_UNSEL;
      else                   code = LV_MID;
    end
    assign com_lvl[2*p +: 2] = code;
  end

  for (genvar j = 0; j < NSEG; j++) begin : g_seg
    lvl_e code;
    always_comb begin
      if (blank_q)       code = LV_UNSEL;
      else if (row_q[j]) code = LV_SEL;
      else               code = LV_UNSEL;
    end
    assign seg_lvl[2*j +: 2] = code;
  end
endmodule

// File: rtl/lcdm_seq.sv
module lcdm_seq #(
  parameter  int NCOM = 9,
  parameter  int NSEG = 43,
  parameter  int LENW = 8,
  localparam int IW   = $clog2(NCOM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     cfg_duty,
  input  logic              cfg_mirror,
  input  logic              cfg_bias3,
  input  logic              cfg_blank,
  input  logic [LENW-1:0]   slot_len,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_row,
  input  logic [NSEG-1:0]   wr_data,
  output logic [2*NCOM-1:0] com_lvl,
  output logic [2*NSEG-1:0] seg_lvl,
  output logic              frame_phase
);
  logic            boundary, load, mirror_q, blank_q, phase_q, restart;
  logic [IW-1:0]   slot_q, slot_nxt, duty_q;
  logic [NSEG-1:0] row_q;

  // the timebase restarts whenever the scan takes a load that is not a boundary
  assign restart = load && !boundary;

  lcdm_timebase #(.LENW(LENW)) u_tb (
    .clk(clk), .rst_n(rst_n), .slot_len(slot_len),
    .restart(restart), .boundary(boundary)
  );

  lcdm_scan #(.NCOM(NCOM), .IW(IW)) u_scan (
    .clk(clk), .rst_n(rst_n), .cfg_duty(cfg_duty), .cfg_mirror(cfg_mirror),
    .cfg_blank(cfg_blank), .boundary(boundary), .load(load),
    .slot_nxt(slot_nxt), .slot_q(slot_q), .duty_q(duty_q),
    .mirror_q(mirror_q), .blank_q(blank_q), .phase_q(phase_q)
  );

  lcdm_dotmem #(.NCOM(NCOM), .NSEG(NSEG), .IW(IW)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .wr_data(wr_data), .load(load), .rd_row(slot_nxt), .row_q(row_q)
  );

  lcdm_drive #(.NCOM(NCOM), .NSEG(NSEG), .IW(IW)) u_drv (
    .slot_q(slot_q), .duty_q(duty_q), .mirror_q(mirror_q),
    .bias3(cfg_bias3), .blank_q(blank_q), .row_q(row_q),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  assign frame_phase = phase_q;
endmodule

// File: rtl/lcdm_seq_chk.sv
module lcdm_seq_chk #(
  parameter int NCOM = 9,
  parameter int NSEG = 43,
  parameter int IW   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*NCOM-1:0] com_lvl,
  input logic [2*NSEG-1:0] seg_lvl,
  input logic              frame_phase,
  input logic [IW-1:0]     slot_q,
  input logic [IW-1:0]     duty_q,
  input logic              mirror_q,
  input logic              blank_q,
  input logic              load,
  input logic              cfg_mirror
);
  logic [NCOM-1:0] com_sel;
  logic [NSEG-1:0] seg_sel;
  logic            past_ok;

  always_comb begin
    for (int p = 0; p < NCOM; p++) com_sel[p] = (com_lvl[2*p +: 2] == 2'd1);
    for (int j = 0; j < NSEG; j++) seg_sel[j] = (seg_lvl[2*j +: 2] == 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R3
  one_com_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(com_sel) == 1);

  // R2
  slot_in_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < duty_q);

  // R6
  phase_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (frame_phase != $past(frame_phase))) |-> (slot_q == '0));

  // R8
  blank_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_q |-> (seg_sel == '0));

  // R9
  mirror_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mirror != mirror_q) |=> (slot_q == '0));

  // R5
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(load)) |-> $stable(seg_lvl));
endmodule

bind lcdm_seq lcdm_seq_chk #(.NCOM(NCOM), .NSEG(NSEG), .IW(IW)) i_chk (
  .clk(clk), .rst_n(rst_n), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
  .frame_phase(frame_phase), .slot_q(slot_q), .duty_q(duty_q),
  .mirror_q(mirror_q), .blank_q(blank_q), .load(load), .cfg_mirror(cfg_mirror)
);

// File: tb/test_lcdm_seq.sv
module test_lcdm_seq;
  localparam int NC = 9;
  localparam int NS = 43;
  localparam int IW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [IW-1:0]   cfg_duty = '0;
  logic            cfg_mirror = 1'b0, cfg_bias3 = 1'b0, cfg_blank = 1'b0;
  logic [7:0]      slot_len = 8'd1;
  logic            wr_en = 1'b0;
  logic [IW-1:0]   wr_row = '0;
  logic [NS-1:0]   wr_data = '0;
  logic [2*NC-1:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;
  logic            frame_phase;

  lcdm_seq i_lcdm_seq (
    .clk(clk), .rst_n(rst_n), .cfg_duty(cfg_duty), .cfg_mirror(cfg_mirror),
    .cfg_bias3(cfg_bias3), .cfg_blank(cfg_blank), .slot_len(slot_len),
    .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl), .frame_phase(frame_phase)
  );

  always #2 clk = ~clk;

  typedef struct {
    int              cyc;
    logic [2*NC-1:0] com;
    logic [2*NS-1:0] seg;
    logic            ph;
    string           tag;
  } item_t;

  item_t         sb_q[$];
  logic [NS-1:0] sh[NC];
  int            cyc;
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic logic [2*NC-1:0] exp_com(int s, int d, bit mir, bit b3);
    logic [2*NC-1:0] v;
    for (int p = 0; p < NC; p++) begin
      int lg;
      lg = mir ? (NC - 1 - p) : p;
      if (lg == s)      v[2*p +: 2] = 2'd1;
      else if (lg >= d) v[2*p +: 2] = 2'd0;
      else if (b3)      v[2*p +: 2] = 2'd2;
      else              v[2*p +: 2] = 2'd3;
    end
    return v;
  endfunction

  function automatic logic [2*NS-1:0] exp_seg(logic [NS-1:0] row, bit blk);
    logic [2*NS-1:0] v;
    for (int j = 0; j < NS; j++) v[2*j +: 2] = (!blk && row[j]) ? 2'd1 : 2'd2;
    return v;
  endfunction

  function automatic logic [NS-1:0] pat(int r, int salt);
    logic [NS-1:0] v;
    v = 43'h3AB_CDEF_0123;
    v = (v << r) ^ (NS'(salt) * 43'h1_0F0F_1357) ^ NS'(r + 1);
    return v;
  endfunction

  // monitor: pops expected items and compares when their cycle comes up
  always @(negedge clk) begin
    if (rst_n) begin
      while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (it.cyc != cyc) begin
          errors++;
          $display("FAIL %s item for cycle %0d missed (now %0d)", it.tag, it.cyc, cyc);
        end else if (com_lvl !== it.com || seg_lvl !== it.seg || frame_phase !== it.ph) begin
          errors++;
          $display("FAIL %s cyc=%0d com act=%h exp=%h seg act=%h exp=%h phase act=%0d exp=%0d",
                   it.tag, cyc, com_lvl, it.com, seg_lvl, it.seg, frame_phase, it.ph);
        end
      end
    end
  end

  task automatic push_slot(int c, int s, int d, bit mir, bit b3, bit blk, bit ph, string tag);
    item_t it;
    it.cyc = c;
    it.com = exp_com(s, d, mir, b3);
    it.seg = exp_seg(sh[s], blk);
    it.ph  = ph;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // global slot index i: frame i/d, slot i%d, start cycle base + i*L
  task automatic push_range(int base, int d, int L, int i0, int i1, bit mir, bit b3,
                            bit blk, bit ph0, string tag);
    for (int i = i0; i <= i1; i++) begin
      push_slot(base + i * L, i % d, d, mir, b3, blk, ph0 ^ bit'((i / d) % 2), tag);
    end
  endtask

  task automatic wait_cyc(int n);
    while (cyc != n) @(negedge clk);
    #1;
  endtask

  task automatic write_row(int r, logic [NS-1:0] data);
    wr_en = 1'b1; wr_row = IW'(r); wr_data = data;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    sh[r] = data;
  endtask

  task automatic fill_rows(int d, int salt);
    for (int r = 0; r < d; r++) begin
      wait_cyc(r + 1);
      write_row(r, pat(r, salt));
    end
  endtask

  task automatic do_reset(int dut_duty, int L, bit mir, bit b3, bit blk);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    cfg_duty = IW'(dut_duty); slot_len = 8'(L);
    cfg_mirror = mir; cfg_bias3 = b3; cfg_blank = blk;
    for (int r = 0; r < NC; r++) sh[r] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state seen at the ports
    checks++;
    if (com_lvl !== exp_com(0, NC, 1'b0, b3) || seg_lvl !== exp_seg('0, 1'b1)
        || frame_phase !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset com act=%h exp=%h seg act=%h exp=%h phase act=%0d exp=0",
               com_lvl, exp_com(0, NC, 1'b0, b3), seg_lvl, exp_seg('0, 1'b1), frame_phase);
    end
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 %0d expected items never reached", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog expired");
      finish_run();
    end
  end

  initial begin
    // A: R2 R3 R5 R6 R7, duty 4, 1/3 bias
    do_reset(4, 12, 1'b0, 1'b1, 1'b0);
    push_range(1, 4, 12, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0, "R2 R3 R7 first slot");
    fill_rows(4, 1);
    push_range(1, 4, 12, 1, 11, 1'b0, 1'b1, 1'b0, 1'b0, "R2 R3 R5 R6 scan");
    wait_cyc(1 + 11 * 12 + 2);

    // B: R10 R4 R3, duty input 0 -> 9, mirrored, 1/2 bias
    do_reset(0, 12, 1'b1, 1'b0, 1'b0);
    push_range(1, 9, 12, 0, 0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 R10 first slot");
    fill_rows(9, 2);
    push_range(1, 9, 12, 1, 17, 1'b1, 1'b0, 1'b0, 1'b0, "R4 R10 R3 mirrored");
    wait_cyc(1 + 17 * 12 + 2);

    // C: R6 duty 1 toggles phase every slot
    do_reset(1, 3, 1'b0, 1'b1, 1'b0);
    push_range(1, 1, 3, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0, "R6 duty1");
    fill_rows(1, 3);
    push_range(1, 1, 3, 1, 5, 1'b0, 1'b1, 1'b0, 1'b0, "R6 duty1 toggle");
    wait_cyc(1 + 5 * 3 + 2);

    // D: R8 blank, then unblank restores stored data
    do_reset(3, 5, 1'b0, 1'b1, 1'b1);
    push_range(1, 3, 5, 0, 0, 1'b0, 1'b1, 1'b1, 1'b0, "R8 blank");
    fill_rows(3, 4);
    push_range(1, 3, 5, 1, 5, 1'b0, 1'b1, 1'b1, 1'b0, "R8 blank");
    wait_cyc(27);
    cfg_blank = 1'b0;
    push_slot(28, 2, 3, 1'b0, 1'b1, 1'b1, 1'b1, "R8 blank held until boundary");
    push_range(1, 3, 5, 6, 8, 1'b0, 1'b1, 1'b0, 1'b0, "R8 unblank shows data");
    wait_cyc(1 + 8 * 5 + 2);

    // E: R7 write colliding with load, R9 mirror then duty change mid-slot
    do_reset(3, 6, 1'b0, 1'b0, 1'b0);
    push_range(1, 3, 6, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 first slot");
    fill_rows(3, 5);
    push_range(1, 3, 6, 1, 2, 1'b0, 1'b0, 1'b0, 1'b0, "R7 collision keeps old row");
    wait_cyc(6);
    write_row(1, ~pat(1, 5));
    push_range(1, 3, 6, 3, 4, 1'b0, 1'b0, 1'b0, 1'b0, "R7 new row next frame");
    wait_cyc(27);
    cfg_mirror = 1'b1;
    push_range(28, 3, 6, 0, 4, 1'b1, 1'b0, 1'b0, 1'b1, "R9 mirror restart");
    wait_cyc(55);
    cfg_duty = IW'(2);
    push_range(56, 2, 6, 0, 3, 1'b1, 1'b0, 1'b0, 1'b0, "R9 duty restart");
    wait_cyc(56 + 3 * 6 + 2);

    done = 1;
    finish_run();
  end
endmodule